// File: doc/BRIEF.md
# Hardware Thread Context Scheduler

This block holds the allocation and scheduling state for a small pool of hardware thread contexts and chooses, every cycle, which context owns the issue slot. Each context carries five independent flags: activated (otherwise free), blocked (otherwise running), halted, offline and suspended. A context may issue only when it is activated, running, not halted, not offline and not suspended. Among the contexts that may issue, the choice rotates, so back-to-back cycles can name different contexts with no switching penalty.

Software-visible control arrives as single-cycle request pulses. A new-thread allocation takes the lowest-numbered context that is free and not halted, and reports success and the chosen index one cycle later. Per-context bit vectors release contexts, park them on a synchronization event, halt or unhalt them, and take them offline or back online for debug. A blocked context wakes when its own external event-ready bit rises. An exception raised by an activated context suspends every other activated context until the exception is cleared.

Top module: `tc_sched`

## Requirements
- R1: After reset, context 0 (parameter `BOOT_CTX`) is activated and running and every other context is free, not halted, not offline and not suspended; context 0 therefore issues every cycle, and `alloc_rsp_valid` is 0.
- R2: An `alloc_req` pulse makes the lowest-numbered context that is free and not halted activated and running; in the following cycle `alloc_rsp_valid` is 1, `alloc_rsp_ok` is 1 and `alloc_rsp_id` gives that index.
- R3: When no context is both free and not halted, an allocation reports `alloc_rsp_ok` = 0 with `alloc_rsp_id` = 0 and changes no context.
- R4: `issue_id` names the first eligible context found by searching upward from one past the last issued context, wrapping from the highest index to 0; the last issued context is taken only when no other is eligible.
- R5: When no context is eligible, `issue_valid` is 0 and the last-issued pointer keeps its value, so issue resumes with the first eligible context above the one issued before the idle period.
- R6: `yield_req[i]` on an activated context blocks it from the next cycle; `event_rdy[i]` while blocked returns it to running from the next cycle.
- R7: A halted context is never issued and never allocated, regardless of its other flags; `halt_set[i]` halts and `halt_clr[i]` unhalts (set wins when both are high).
- R8: `offline_set[i]` on an activated context keeps it out of issue until `offline_clr[i]`.
- R9: `exc_raise` with an activated `exc_id` suspends every other activated context from the next cycle; `exc_clear` releases all suspended contexts.
- R10: `dealloc_req[i]` returns context i to free, clearing its blocked, offline and suspended flags; it is no longer issued and becomes available to allocation again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request one new context |
| dealloc_req | input | NUM_CTX | Per-context release pulses |
| yield_req | input | NUM_CTX | Per-context block-on-event pulses |
| event_rdy | input | NUM_CTX | Per-context external ready condition |
| halt_set | input | NUM_CTX | Per-context halt pulses |
| halt_clr | input | NUM_CTX | Per-context unhalt pulses |
| offline_set | input | NUM_CTX | Per-context debug offline pulses |
| offline_clr | input | NUM_CTX | Per-context debug online pulses |
| exc_raise | input | 1 | Exception raised by context `exc_id` |
| exc_id | input | $clog2(NUM_CTX) | Context raising the exception |
| exc_clear | input | 1 | Exception handled, release suspension |
| issue_valid | output | 1 | A context holds the issue slot this cycle |
| issue_id | output | $clog2(NUM_CTX) | Context holding the issue slot |
| alloc_rsp_valid | output | 1 | Allocation result present |
| alloc_rsp_ok | output | 1 | Allocation succeeded |
| alloc_rsp_id | output | $clog2(NUM_CTX) | Allocated context index |

## Verification
The bench builds the block with its defaults, eight contexts and boot context 0, which makes every context reachable by a few allocations so the pool can be filled and the failure path of allocation hit. Eight slots give room to hold several flags on different contexts at once, so rotation is observed skipping blocked, halted, offline and suspended contexts in one run and wrapping from index 7 back to 0. Halting the whole pool exercises the idle case and the pointer retention across it.

// File: rtl/tc_sched_pkg.sv
package tc_sched_pkg;

   typedef struct packed {
      logic active;
      logic blocked;
      logic halted;
      logic offline;
      logic susp;
   } ctx_flags_t;

   localparam ctx_flags_t CTX_FREE = '{active: 1'b0, blocked: 1'b0, halted: 1'b0,
                                      offline: 1'b0, susp: 1'b0};
   localparam ctx_flags_t CTX_BOOT = '{active: 1'b1, blocked: 1'b0, halted: 1'b0,
                                      offline: 1'b0, susp: 1'b0};

endpackage

// File: rtl/tcs_ctx_slot.sv
module tcs_ctx_slot
   import tc_sched_pkg::*;
#(
   parameter bit BOOT_ACTIVE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       alloc_hit,
   input  logic       dealloc_hit,
   input  logic       yield_hit,
   input  logic       event_hit,
   input  logic       halt_set,
   input  logic       halt_clr,
   input  logic       off_set,
   input  logic       off_clr,
   input  logic       susp_set,
   input  logic       susp_clr,
   output ctx_flags_t flags,
   output logic       eligible
);

   ctx_flags_t q;
   localparam ctx_flags_t RST_VAL = BOOT_ACTIVE ? CTX_BOOT : CTX_FREE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else begin
         if (halt_set)      q.halted <= 1'b1;
         else if (halt_clr) q.halted <= 1'b0;

         if (dealloc_hit) begin
            q.active  <= 1'b0;
            q.blocked <= 1'b0;
            q.offline <= 1'b0;
            q.susp    <= 1'b0;
         end else if (alloc_hit) begin
            q.active  <= 1'b1;
            q.blocked <= 1'b0;
            q.offline <= 1'b0;
            q.susp    <= 1'b0;
         end else if (q.active) begin
            if (yield_hit)      q.blocked <= 1'b1;
            else if (event_hit) q.blocked <= 1'b0;

            if (off_set)      q.offline <= 1'b1;
            else if (off_clr) q.offline <= 1'b0;

            if (susp_clr)      q.susp <= 1'b0;
            else if (susp_set) q.susp <= 1'b1;
         end
      end
   end

   assign flags    = q;
   assign eligible = q.active & ~q.blocked & ~q.halted & ~q.offline & ~q.susp;

endmodule

// File: rtl/tcs_rr_pick.sv
module tcs_rr_pick #(
   parameter int NUM_CTX = 8,
   localparam int ID_W   = $clog2(NUM_CTX)
) (
   input  logic [NUM_CTX-1:0] elig,
   input  logic [ID_W-1:0]    last_id,
   output logic               valid,
   output logic [ID_W-1:0]    id
);

   always_comb begin
      valid = 1'b0;
      id    = '0;
      for (int off = 1; off <= NUM_CTX; off++) begin
         int cand;
         cand = int'(last_id) + off;
         if (cand >= NUM_CTX) cand = cand - NUM_CTX;
         if (!valid && elig[cand]) begin
            valid = 1'b1;
            id    = ID_W'(cand);
         end
      end
   end

endmodule

// File: rtl/tcs_lowest_free.sv
module tcs_lowest_free #(
   parameter int NUM_CTX = 8,
   localparam int ID_W   = $clog2(NUM_CTX)
) (
   input  logic [NUM_CTX-1:0] avail,
   output logic               found,
   output logic [ID_W-1:0]    id
);

   always_comb begin
      found = 1'b0;
      id    = '0;
      for (int i = NUM_CTX - 1; i >= 0; i--) begin
         if (avail[i]) begin
            found = 1'b1;
            id    = ID_W'(i);
         end
      end
   end

endmodule

// File: rtl/tc_sched.sv
module tc_sched
   import tc_sched_pkg::*;
#(
   parameter int NUM_CTX  = 8,
   parameter int BOOT_CTX = 0,
   localparam int ID_W    = $clog2(NUM_CTX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc_req,
   input  logic [NUM_CTX-1:0] dealloc_req,
   input  logic [NUM_CTX-1:0] yield_req,
   input  logic [NUM_CTX-1:0] event_rdy,
   input  logic [NUM_CTX-1:0] halt_set,
   input  logic [NUM_CTX-1:0] halt_clr,
   input  logic [NUM_CTX-1:0] offline_set,
   input  logic [NUM_CTX-1:0] offline_clr,
   input  logic               exc_raise,
   input  logic [ID_W-1:0]    exc_id,
   input  logic               exc_clear,
   output logic               issue_valid,
   output logic [ID_W-1:0]    issue_id,
   output logic               alloc_rsp_valid,
   output logic               alloc_rsp_ok,
   output logic [ID_W-1:0]    alloc_rsp_id
);

   initial begin
      assert (NUM_CTX >= 2 && NUM_CTX <= 64)
         else $error("tc_sched: NUM_CTX must lie in 2..64");
      assert (BOOT_CTX >= 0 && BOOT_CTX < NUM_CTX)
         else $error("tc_sched: BOOT_CTX outside the pool");
   end

   ctx_flags_t         flags [NUM_CTX];
   logic [NUM_CTX-1:0] elig_v;
   logic [NUM_CTX-1:0] active_v, blocked_v, halted_v, offline_v, susp_v;
   logic [NUM_CTX-1:0] alloc_hit_v;
   logic               alloc_found;
   logic [ID_W-1:0]    alloc_pick;
   logic               exc_ok;
   logic [ID_W-1:0]    rr_ptr;

   assign exc_ok = exc_raise & active_v[exc_id];

   tcs_lowest_free #(.NUM_CTX(NUM_CTX)) u_alloc (
      .avail (~active_v & ~halted_v),
      .found (alloc_found),
      .id    (alloc_pick)
   );

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
      assign alloc_hit_v[g] = alloc_req & alloc_found & (alloc_pick == ID_W'(g));

      tcs_ctx_slot #(.BOOT_ACTIVE(g == BOOT_CTX)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .alloc_hit   (alloc_hit_v[g]),
         .dealloc_hit (dealloc_req[g]),
         .yield_hit   (yield_req[g]),
         .event_hit   (event_rdy[g]),
         .halt_set    (halt_set[g]),
         .halt_clr    (halt_clr[g]),
         .off_set     (offline_set[g]),
         .off_clr     (offline_clr[g]),
         .susp_set    (exc_ok & (exc_id != ID_W'(g))),
         .susp_clr    (exc_clear),
         .flags       (flags[g]),
         .eligible    (elig_v[g])
      );

      assign active_v[g]  = flags[g].active;
      assign blocked_v[g] = flags[g].blocked;
      assign halted_v[g]  = flags[g].halted;
      assign offline_v[g] = flags[g].offline;
      assign susp_v[g]    = flags[g].susp;
   end

   tcs_rr_pick #(.NUM_CTX(NUM_CTX)) u_pick (
      .elig    (elig_v),
      .last_id (rr_ptr),
      .valid   (issue_valid),
      .id      (issue_id)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_ptr          <= ID_W'(NUM_CTX - 1);
         alloc_rsp_valid <= 1'b0;
         alloc_rsp_ok    <= 1'b0;
         alloc_rsp_id    <= '0;
      end else begin
         if (issue_valid) rr_ptr <= issue_id;
         alloc_rsp_valid <= alloc_req;
         alloc_rsp_ok    <= alloc_req & alloc_found;
         alloc_rsp_id    <= (alloc_req & alloc_found) ? alloc_pick : '0;
      end
   end

endmodule

// File: rtl/tc_sched_chk.sv
module tc_sched_chk #(
   parameter int NUM_CTX  = 8,
   localparam int ID_W    = $clog2(NUM_CTX)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               alloc_req,
   input logic               issue_valid,
   input logic [ID_W-1:0]    issue_id,
   input logic [ID_W-1:0]    rr_ptr,
   input logic               alloc_rsp_valid,
   input logic               alloc_rsp_ok,
   input logic [ID_W-1:0]    alloc_rsp_id,
   input logic [NUM_CTX-1:0] active_v,
   input logic [NUM_CTX-1:0] blocked_v,
   input logic [NUM_CTX-1:0] halted_v,
   input logic [NUM_CTX-1:0] offline_v,
   input logic [NUM_CTX-1:0] susp_v
);

   p_issue_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (active_v[issue_id] && !blocked_v[issue_id]));

   p_idle_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> $stable(rr_ptr));

   p_issue_not_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !halted_v[issue_id]);

   p_issue_not_offline_r8: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !offline_v[issue_id]);

   p_issue_not_susp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !susp_v[issue_id]);

   p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_req |=> alloc_rsp_valid);

   p_alloc_ok_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_rsp_valid && alloc_rsp_ok) |-> active_v[alloc_rsp_id]);

   p_alloc_fail_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_req && ((~active_v & ~halted_v) == '0) |=> !alloc_rsp_ok);

endmodule

bind tc_sched tc_sched_chk #(.NUM_CTX(NUM_CTX)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .alloc_req       (alloc_req),
   .issue_valid     (issue_valid),
   .issue_id        (issue_id),
   .rr_ptr          (rr_ptr),
   .alloc_rsp_valid (alloc_rsp_valid),
   .alloc_rsp_ok    (alloc_rsp_ok),
   .alloc_rsp_id    (alloc_rsp_id),
   .active_v        (active_v),
   .blocked_v       (blocked_v),
   .halted_v        (halted_v),
   .offline_v       (offline_v),
   .susp_v          (susp_v)
);

// File: tb/tc_sched_tb_top.sv
`timescale 1ns/1ps
module tc_sched_tb_top;

   localparam int NC   = 8;
   localparam int ID_W = $clog2(NC);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            alloc_req = 1'b0;
   logic [NC-1:0]   dealloc_req = '0, yield_req = '0, event_rdy = '0;
   logic [NC-1:0]   halt_set = '0, halt_clr = '0, offline_set = '0, offline_clr = '0;
   logic            exc_raise = 1'b0, exc_clear = 1'b0;
   logic [ID_W-1:0] exc_id = '0;
   logic            issue_valid, alloc_rsp_valid, alloc_rsp_ok;
   logic [ID_W-1:0] issue_id, alloc_rsp_id;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [NC-1:0] exp_mask;
   int            exp_ptr;

   always #2.5 clk = ~clk;

   tc_sched #(.NUM_CTX(NC), .BOOT_CTX(0)) dut_i (
      .clk (clk), .rst_n (rst_n), .alloc_req (alloc_req),
      .dealloc_req (dealloc_req), .yield_req (yield_req), .event_rdy (event_rdy),
      .halt_set (halt_set), .halt_clr (halt_clr),
      .offline_set (offline_set), .offline_clr (offline_clr),
      .exc_raise (exc_raise), .exc_id (exc_id), .exc_clear (exc_clear),
      .issue_valid (issue_valid), .issue_id (issue_id),
      .alloc_rsp_valid (alloc_rsp_valid), .alloc_rsp_ok (alloc_rsp_ok),
      .alloc_rsp_id (alloc_rsp_id)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Expected issue: first context in exp_mask above exp_ptr, wrapping.
   task automatic check_issue(input string req);
      logic v = 1'b0;
      int   id = 0;
      for (int off = 1; off <= NC; off++) begin
         int t = (exp_ptr + off) % NC;
         if (!v && exp_mask[t]) begin
            v  = 1'b1;
            id = t;
         end
      end
      check(issue_valid === v, req, "issue_valid", int'(issue_valid), int'(v));
      if (v) begin
         check(issue_id === ID_W'(id), req, "issue_id", int'(issue_id), id);
         exp_ptr = id;
      end
   endtask

   task automatic cyc(input string req);
      #1;
      check_issue(req);
      @(posedge clk);
      #1;
   endtask

   task automatic run(input int n, input string req);
      for (int k = 0; k < n; k++) cyc(req);
   endtask

   task automatic do_alloc(input bit ok, input int id, input string req);
      alloc_req = 1'b1;
      cyc(req);
      alloc_req = 1'b0;
      check(alloc_rsp_valid === 1'b1, req, "alloc_rsp_valid", int'(alloc_rsp_valid), 1);
      check(alloc_rsp_ok === ok, req, "alloc_rsp_ok", int'(alloc_rsp_ok), int'(ok));
      check(alloc_rsp_id === ID_W'(id), req, "alloc_rsp_id", int'(alloc_rsp_id), id);
      if (ok) exp_mask[id] = 1'b1;
   endtask

   task automatic t_reset;  // R1
      exp_mask = 8'b0000_0001;
      exp_ptr  = NC - 1;
      check(alloc_rsp_valid === 1'b0, "R1", "alloc_rsp_valid", int'(alloc_rsp_valid), 0);
      run(3, "R1");
   endtask

   task automatic t_alloc_rr;  // R2, R4
      do_alloc(1'b1, 1, "R2");
      do_alloc(1'b1, 2, "R2");
      do_alloc(1'b1, 3, "R2");
      run(6, "R4");
   endtask

   task automatic t_yield;  // R6
      yield_req[2] = 1'b1;
      cyc("R6");
      yield_req[2] = 1'b0;
      exp_mask[2] = 1'b0;
      run(4, "R6");
      event_rdy[2] = 1'b1;
      cyc("R6");
      event_rdy[2] = 1'b0;
      exp_mask[2] = 1'b1;
      run(4, "R6");
   endtask

   task automatic t_halt;  // R7
      halt_set[1] = 1'b1;
      halt_set[4] = 1'b1;
      cyc("R7");
      halt_set = '0;
      exp_mask[1] = 1'b0;
      run(3, "R7");
      do_alloc(1'b1, 5, "R7");
      run(3, "R7");
      halt_clr[1] = 1'b1;
      halt_clr[4] = 1'b1;
      cyc("R7");
      halt_clr = '0;
      exp_mask[1] = 1'b1;
      run(6, "R7");
   endtask

   task automatic t_offline;  // R8
      offline_set[3] = 1'b1;
      cyc("R8");
      offline_set = '0;
      exp_mask[3] = 1'b0;
      run(5, "R8");
      offline_clr[3] = 1'b1;
      cyc("R8");
      offline_clr = '0;
      exp_mask[3] = 1'b1;
      run(5, "R8");
   endtask

   task automatic t_exception;  // R9
      logic [NC-1:0] saved;
      saved = exp_mask;
      exc_raise = 1'b1;
      exc_id    = ID_W'(2);
      cyc("R9");
      exc_raise = 1'b0;
      exp_mask = 8'b0000_0100;
      run(4, "R9");
      exc_clear = 1'b1;
      cyc("R9");
      exc_clear = 1'b0;
      exp_mask = saved;
      run(6, "R9");
   endtask

   task automatic t_fill;  // R3
      do_alloc(1'b1, 4, "R3");
      do_alloc(1'b1, 6, "R3");
      do_alloc(1'b1, 7, "R3");
      do_alloc(1'b0, 0, "R3");
      run(9, "R3");
   endtask

   task automatic t_dealloc;  // R10
      dealloc_req[5] = 1'b1;
      cyc("R10");
      dealloc_req = '0;
      exp_mask[5] = 1'b0;
      run(8, "R10");
      do_alloc(1'b1, 5, "R10");
      run(8, "R10");
   endtask

   task automatic t_idle;  // R5
      halt_set = '1;
      cyc("R5");
      halt_set = '0;
      exp_mask = '0;
      run(4, "R5");
      halt_clr = '1;
      cyc("R5");
      halt_clr = '0;
      exp_mask = '1;
      run(10, "R5");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_alloc_rr();
      t_yield();
      t_halt();
      t_offline();
      t_exception();
      t_fill();
      t_dealloc();
      t_idle();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule